// File: doc/BRIEF.md
# Alignment History Combining Predictor

This block sits in a decode front end and decides, for each memory instruction, whether it should be fused with its neighbour into a single doubleword access. It holds a direct-mapped, tagged table indexed by the instruction address. Each entry keeps a short shift history of alignment outcomes that the memory system reported for that instruction.

A lookup presents an instruction address and gets back a single combine bit in the same cycle. Combining is predicted only when the entry's tag matches and its history shows one of two shapes. One shape is an unbroken run of aligned outcomes. The other is a strict alternation, which is what a base address that moves forward by one word per instance produces.

The update port carries an instruction address and the aligned or misaligned outcome for it. When the tag matches, the outcome is shifted into the entry. When it does not match, the entry is reallocated for the new address.

The update path is described by three named update states:
- `UPD_IDLE`: no update this cycle.
- `UPD_TRAIN`: the tag hit, so the history is shifted.
- `UPD_ALLOC`: the tag missed, so the entry is rewritten.

The lookup path classifies the stored history into one of three classes:
- `HC_STEADY`: the history is all ones.
- `HC_STRIDE`: the history is alternating.
- `HC_MIXED`: anything else.

The update state is chosen afresh every cycle from `up_valid` and the tag compare. It returns to `UPD_IDLE` whenever `up_valid` is low.

Top module: `comb_pred_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup returns `lk_combine` = 0 until an update has been made.
- R2: The entry index is PC bits [11:2] and the tag is PC bits [31:12]. PC bits [1:0] do not affect lookup or update. A lookup whose index selects a valid entry with a different tag returns 0.
- R3: An update that hits (valid entry, equal tag) shifts the history left by one, placing the new outcome in bit 0 (the newest) and dropping bit 3 (the oldest).
- R4: A hitting lookup whose history is 4'b1111 returns `lk_combine` = 1.
- R5: A hitting lookup whose history is 4'b1010 (newest outcome misaligned, then aligned, misaligned, aligned) returns `lk_combine` = 1.
- R6: A hitting lookup with any other history value returns 0.
- R7: An update that misses writes the new tag and sets the history to {3'b000, outcome}, replacing whatever the entry held before.
- R8: A lookup and an update to the same entry in the same cycle return the prediction from the history held before that update. The update's effect appears from the next cycle.
- R9: `lk_combine` is 0 whenever `lk_valid` is 0.
- R10: When `up_valid` is 0, the table is unchanged whatever `up_pc` and `up_aligned` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid bits |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_pc | input | 32 | Instruction address being looked up |
| lk_combine | output | 1 | Combinational prediction: fuse this access with its neighbour |
| up_valid | input | 1 | Training request qualifier |
| up_pc | input | 32 | Instruction address whose outcome is reported |
| up_aligned | input | 1 | 1 when the access was found doubleword-aligned |

## Verification
The assertions assume that `up_valid` is held low while `rst_n` is low. They also assume that at most one outcome per cycle arrives on the update port. The same-cycle visibility rule is checked only against an address that was updated on the previous cycle. The bench keeps the update inputs idle during reset and issues at most one update per cycle.

Its directed phases reuse a handful of addresses that collide on one index with different tags. This exercises reallocation, streak building and alternation. A pseudo-random phase then draws from the same small address set, so that hits, misses and same-cycle collisions all recur often.

// File: rtl/comb_pred_pkg.sv
package comb_pred_pkg;

    typedef enum logic [1:0] {
        HC_STEADY,
        HC_STRIDE,
        HC_MIXED
    } hist_class_e;

    typedef enum logic [1:0] {
        UPD_IDLE,
        UPD_TRAIN,
        UPD_ALLOC
    } upd_state_e;

endpackage

// File: rtl/comb_pred_split.sv
module comb_pred_split #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 10,
    parameter int IDX_LSB = 2,
    localparam int TAG_W  = PC_W - IDX_W - IDX_LSB
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    logic [IDX_LSB-1:0] unused_offset;

    assign idx           = pc[IDX_LSB +: IDX_W];
    assign tag           = pc[PC_W-1 -: TAG_W];
    assign unused_offset = pc[IDX_LSB-1:0];
endmodule

// File: rtl/comb_pred_classify.sv
module comb_pred_classify
    import comb_pred_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              en,
    input  logic              hit,
    input  logic [HIST_W-1:0] hist,
    output logic              combine
);
    function automatic logic [HIST_W-1:0] stride_pattern();
        logic [HIST_W-1:0] p;
        for (int i = 0; i < HIST_W; i++) begin
            p[i] = i[0];
        end
        return p;
    endfunction

    localparam logic [HIST_W-1:0] PAT_STEADY = '1;
    localparam logic [HIST_W-1:0] PAT_STRIDE = stride_pattern();

    hist_class_e cls;

    always_comb begin
        if (hist == PAT_STEADY) begin
            cls = HC_STEADY;
        end else if (hist == PAT_STRIDE) begin
            cls = HC_STRIDE;
        end else begin
            cls = HC_MIXED;
        end
    end

    always_comb begin
        combine = 1'b0;
        unique case (cls)
            HC_STEADY: combine = en & hit;
            HC_STRIDE: combine = en & hit;
            HC_MIXED:  combine = 1'b0;
            default:   combine = 1'b0;
        endcase
    end
endmodule

// File: rtl/comb_pred_table.sv
module comb_pred_table
    import comb_pred_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int HIST_W = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic              up_aligned,
    output logic              up_hit,
    output logic [HIST_W-1:0] up_hist_old
);
    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [HIST_W-1:0] hist_q [DEPTH];

    upd_state_e        upd_state;
    logic [HIST_W-1:0] hist_new;

    assign lk_hit      = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_hist     = hist_q[lk_idx];
    assign up_hit      = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
    assign up_hist_old = hist_q[up_idx];

    always_comb begin
        if (!up_valid) begin
            upd_state = UPD_IDLE;
        end else if (up_hit) begin
            upd_state = UPD_TRAIN;
        end else begin
            upd_state = UPD_ALLOC;
        end
    end

    always_comb begin
        hist_new = up_hist_old;
        unique case (upd_state)
            UPD_IDLE:  hist_new = up_hist_old;
            UPD_TRAIN: hist_new = {up_hist_old[HIST_W-2:0], up_aligned};
            UPD_ALLOC: hist_new = {{(HIST_W-1){1'b0}}, up_aligned};
            default:   hist_new = up_hist_old;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (upd_state == UPD_ALLOC) begin
            valid_q[up_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && upd_state != UPD_IDLE) begin
            tag_q[up_idx]  <= up_tag;
            hist_q[up_idx] <= hist_new;
        end
    end
endmodule

// File: rtl/comb_pred_top.sv
module comb_pred_top #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 10,
    parameter int IDX_LSB = 2,
    parameter int HIST_W  = 4,
    localparam int TAG_W  = PC_W - IDX_W - IDX_LSB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_combine,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_aligned
);
    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              lk_hit, up_hit;
    logic [HIST_W-1:0] lk_hist, up_hist_old;

    comb_pred_split #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) lk_split_i (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
    );

    comb_pred_split #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) up_split_i (
        .pc(up_pc), .idx(up_idx), .tag(up_tag)
    );

    comb_pred_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W)) table_i (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_hist(lk_hist),
        .up_valid(up_valid), .up_idx(up_idx), .up_tag(up_tag),
        .up_aligned(up_aligned), .up_hit(up_hit), .up_hist_old(up_hist_old)
    );

    comb_pred_classify #(.HIST_W(HIST_W)) classify_i (
        .en(lk_valid), .hit(lk_hit), .hist(lk_hist), .combine(lk_combine)
    );
endmodule

// File: rtl/comb_pred_chk.sv
module comb_pred_chk #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_combine,
    input logic              up_valid,
    input logic [PC_W-1:0]   up_pc,
    input logic              up_aligned,
    input logic              lk_hit,
    input logic [HIST_W-1:0] lk_hist,
    input logic              up_hit,
    input logic [HIST_W-1:0] up_hist_old
);
    // R9
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_combine);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> !lk_combine);

    // R2, R6
    a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lk_combine |-> lk_hit);

    // R4, R5
    a_r5_pattern_only: assert property (@(posedge clk) disable iff (!rst_n)
        lk_combine |-> ($countones(lk_hist) == HIST_W || lk_hist == 4'b1010));

    // R3
    a_r3_train_shift: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_valid) && $past(up_hit) && lk_pc == $past(up_pc))
        |-> (lk_hit && lk_hist == {$past(up_hist_old[HIST_W-2:0]), $past(up_aligned)}));

    // R7
    a_r7_alloc_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_valid) && !$past(up_hit) && lk_pc == $past(up_pc))
        |-> (lk_hit && lk_hist == {{(HIST_W-1){1'b0}}, $past(up_aligned)}));

    // R8, R10
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(up_valid) && lk_valid && $past(lk_valid)
         && lk_pc == $past(lk_pc)) |-> $stable(lk_combine));
endmodule

bind comb_pred_top comb_pred_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_combine(lk_combine), .up_valid(up_valid), .up_pc(up_pc),
    .up_aligned(up_aligned), .lk_hit(lk_hit), .lk_hist(lk_hist),
    .up_hit(up_hit), .up_hist_old(up_hist_old)
);

// File: tb/comb_pred_top_tb_top.sv
module comb_pred_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_combine;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_aligned = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    bit m_valid [int];
    int m_tag   [int];
    int m_hist  [int];

    always #(CLK_PERIOD / 2) clk = ~clk;

    comb_pred_top dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_combine(lk_combine), .up_valid(up_valid), .up_pc(up_pc),
        .up_aligned(up_aligned)
    );

    function automatic bit model_predict(bit v, logic [31:0] pc);
        int idx = int'(pc[11:2]);
        int tg  = int'(pc[31:12]);
        if (!v) return 0;
        if (!m_valid.exists(idx) || !m_valid[idx] || m_tag[idx] != tg) return 0;
        return (m_hist[idx] == 15) || (m_hist[idx] == 10);
    endfunction

    function automatic void model_update(bit v, logic [31:0] pc, bit al);
        int idx = int'(pc[11:2]);
        int tg  = int'(pc[31:12]);
        if (!v) return;
        if (m_valid.exists(idx) && m_valid[idx] && m_tag[idx] == tg) begin
            m_hist[idx] = ((m_hist[idx] << 1) | int'(al)) & 15;
        end else begin
            m_valid[idx] = 1;
            m_tag[idx]   = tg;
            m_hist[idx]  = int'(al);
        end
    endfunction

    task automatic step(input bit lv, input logic [31:0] lp,
                        input bit uv, input logic [31:0] upc, input bit ua,
                        input string req);
        bit exp;
        lk_valid   = lv;
        lk_pc      = lp;
        up_valid   = uv;
        up_pc      = upc;
        up_aligned = ua;
        @(negedge clk);
        exp = model_predict(lv, lp);
        checks++;
        if (lk_combine !== exp) begin
            failures++;
            $display("FAIL %s: lk_combine=%0b expected %0b (pc=%h)", req, lk_combine, exp, lp);
        end
        @(posedge clk);
        model_update(uv, upc, ua);
        #1;
    endtask

    task automatic train(input logic [31:0] pc, input bit al, input string req);
        step(1'b1, pc, 1'b1, pc, al, req);
        step(1'b1, pc, 1'b0, 32'h0, 1'b0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 150000);
            finish_run();
        end
    end

    localparam logic [31:0] PC_A = 32'h0040_1230;
    localparam logic [31:0] PC_B = 32'h0040_1554;
    localparam logic [31:0] PC_C = PC_A + 32'h1000;

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: nothing predicts after reset
        step(1'b1, PC_A, 1'b0, 32'h0, 1'b0, "R1");
        step(1'b1, PC_B, 1'b0, 32'h0, 1'b0, "R1");
        step(1'b1, 32'h0, 1'b0, 32'h0, 1'b0, "R1");

        // R7/R3/R4: streak builds 0001,0011,0111,1111
        train(PC_A, 1'b1, "R7");
        train(PC_A, 1'b1, "R3");
        train(PC_A, 1'b1, "R6");
        train(PC_A, 1'b1, "R4");

        // R2: low PC bits ignored, aliasing tag misses
        step(1'b1, PC_A | 32'h3, 1'b0, 32'h0, 1'b0, "R2");
        step(1'b1, PC_C, 1'b0, 32'h0, 1'b0, "R2");

        // R9: lookup not valid
        step(1'b0, PC_A, 1'b0, 32'h0, 1'b0, "R9");

        // R10: update inputs without up_valid leave state alone
        step(1'b1, PC_A, 1'b0, PC_A, 1'b0, "R10");
        step(1'b1, PC_A, 1'b0, PC_C, 1'b0, "R10");
        step(1'b1, PC_A, 1'b0, 32'h0, 1'b0, "R10");

        // R8: same-cycle update sees old history (1111 -> 1110)
        step(1'b1, PC_A, 1'b1, PC_A, 1'b0, "R8");
        step(1'b1, PC_A, 1'b0, 32'h0, 1'b0, "R6");

        // R5: alternation 0001,0010,0101,1010 then 0101
        train(PC_B, 1'b1, "R7");
        train(PC_B, 1'b0, "R3");
        train(PC_B, 1'b1, "R6");
        train(PC_B, 1'b0, "R5");
        train(PC_B, 1'b1, "R6");

        // R7: aliasing update replaces entry of A
        train(PC_C, 1'b1, "R7");
        step(1'b1, PC_A, 1'b0, 32'h0, 1'b0, "R7");
        train(PC_C, 1'b1, "R3");
        train(PC_C, 1'b1, "R3");
        // R8: lookup with update that completes the streak sees old
        step(1'b1, PC_C, 1'b1, PC_C, 1'b1, "R8");
        step(1'b1, PC_C, 1'b0, 32'h0, 1'b0, "R4");

        // Mixed traffic over a colliding address set, compared each cycle
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] lp, upc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            lp  = 32'h0040_1000 + {28'h0, lfsr[1:0], 2'b00} + (lfsr[2] ? 32'h1000 : 32'h0);
            upc = 32'h0040_1000 + {28'h0, lfsr[4:3], 2'b00} + (lfsr[5] ? 32'h1000 : 32'h0);
            step(lfsr[6] | lfsr[7], lp, lfsr[8] | lfsr[9], upc,
                 lfsr[10] | lfsr[11] | lfsr[12], "R3");
        end

        finish_run();
    end
endmodule